// File: doc/BRIEF.md
# Temporally Programmed Address Generator

This block drives the address side of one port of a small register file. A configuration bundle on the input ports selects one of four spatial patterns: a linear stride, a stride that wraps inside a window, an index with its bits mirrored, and a serpentine walk over rows. The same bundle sets three delays that shape the stream in time, and a replay count. A one-cycle start pulse copies the whole bundle into the block, and from then on the stream runs without further input. Each port of the register file is meant to have its own copy of this block, so two read ports and two write ports use four instances.

Every clock cycle the block shows an address together with a strobe that marks whether that cycle carries a real address. After the final address of the final replay it raises a one-cycle completion flag. A start pulse that arrives while a stream is running has no effect. Once the completion flag is up, the block accepts the next start in that same cycle.

Top module: `rf_agu`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `addr_vld_o` and `done_o` are low.
- R2: Mode 0 (linear) issues address i of a pass as (`cfg_base` + i·`cfg_step`) modulo 2^ADDR_W, for i from 0 to `cfg_count`−1 (`cfg_count` ≥ 1).
- R3: Mode 1 (circular) issues address i as `cfg_lo` + ((`cfg_base` − `cfg_lo`) + i·`cfg_step`) mod (`cfg_hi` − `cfg_lo` + 1). This applies when `cfg_lo` ≤ `cfg_base` ≤ `cfg_hi` and `cfg_step` ≤ `cfg_hi` − `cfg_lo` + 1, and every such address lies within [`cfg_lo`, `cfg_hi`].
- R4: Mode 2 (bit-reverse) issues address i as `cfg_base` plus the low `cfg_rev_bits` bits of i written in reverse order, modulo 2^ADDR_W (1 ≤ `cfg_rev_bits` ≤ ADDR_W).
- R5: Mode 3 (zig-zag) uses rows of width W = `cfg_row_len` (W ≥ 1). For address i it takes row r = i/W and column c = i mod W, and issues `cfg_base` + r·W + c when r is even, or `cfg_base` + r·W + (W−1−c) when r is odd, modulo 2^ADDR_W.
- R6: A start sampled at clock edge n, with the block idle, gives its first address in the cycle after edge n + 1 + `cfg_init_dly`.
- R7: Within a pass, consecutive addresses are `cfg_mid_dly` + 1 cycles apart, so a delay of zero gives addresses back to back.
- R8: The stream runs `cfg_repeat` + 1 passes. The first address of each later pass comes `cfg_rep_dly` + 1 cycles after the last address of the pass before it.
- R9: `done_o` is high for exactly one cycle, the cycle after the last address of the final pass, and `addr_vld_o` is low in that cycle.
- R10: A start sampled at an edge that follows a cycle in which the block was busy is ignored. The block is busy from the cycle after an accepted start through the last address cycle. A start sampled at the edge after the `done_o` cycle is accepted.
- R11: `addr_vld_o` is high only in the address cycles defined above and is low in every other cycle.
- R12: The configuration is captured only at an accepted start. Changes on the configuration ports while a stream runs do not alter that stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Launch pulse, sampled when idle |
| cfg_mode | input | 2 | Pattern: 0 linear, 1 circular, 2 bit-reverse, 3 zig-zag |
| cfg_base | input | ADDR_W | First address / base offset |
| cfg_step | input | ADDR_W | Stride for linear and circular modes |
| cfg_count | input | ADDR_W+1 | Addresses per pass |
| cfg_lo | input | ADDR_W | Lower window bound, circular mode |
| cfg_hi | input | ADDR_W | Upper window bound, circular mode |
| cfg_row_len | input | ADDR_W | Row width, zig-zag mode |
| cfg_rev_bits | input | clog2(ADDR_W+1) | Number of mirrored bits, bit-reverse mode |
| cfg_init_dly | input | DLY_W | Idle cycles before the first address |
| cfg_mid_dly | input | DLY_W | Idle cycles between addresses of a pass |
| cfg_rep_dly | input | DLY_W | Idle cycles between passes |
| cfg_repeat | input | REP_W | Extra passes after the first |
| addr_o | output | ADDR_W | Address, meaningful when the strobe is high |
| addr_vld_o | output | 1 | Address strobe |
| done_o | output | 1 | One-cycle completion flag |

## Verification
The bound checker tests, on every cycle, the properties that hold at any instant. The completion flag lasts one cycle, comes right after an address cycle and never coincides with the strobe. A circular address always stays inside its captured window. An idle block with no start shows no strobe in the next cycle. A start that arrives while busy leaves the captured configuration unchanged. The exact address values of each pattern cannot be seen this way, and neither can the cycle spacing set by the three delays, the number of passes, or the boundary where a start exactly at the completion edge is refused or accepted. Only the bench can show these, because its reference model predicts the address and strobe for every cycle of each scenario.

// File: rtl/rf_agu_pkg.sv
package rf_agu_pkg;

    typedef enum logic [1:0] {
        M_LINEAR = 2'd0,
        M_CIRC   = 2'd1,
        M_BREV   = 2'd2,
        M_ZIGZAG = 2'd3
    } agu_mode_e;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_WAIT = 2'd1,
        S_EMIT = 2'd2,
        S_FIN  = 2'd3
    } agu_state_e;

endpackage

// File: rtl/rf_agu_bitrev.sv
module rf_agu_bitrev #(
    parameter int W = 6
) (
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    for (genvar b = 0; b < W; b++) begin : g_mirror
        assign dout[b] = din[W-1-b];
    end
endmodule

// File: rtl/rf_agu_pattern.sv
module rf_agu_pattern
    import rf_agu_pkg::*;
#(
    parameter int ADDR_W = 6,
    localparam int RB_W = $clog2(ADDR_W + 1)
) (
    input  agu_mode_e          mode,
    input  logic [ADDR_W-1:0]  base,
    input  logic [ADDR_W-1:0]  step,
    input  logic [ADDR_W-1:0]  lo,
    input  logic [ADDR_W-1:0]  hi,
    input  logic [ADDR_W-1:0]  row_len,
    input  logic [RB_W-1:0]    rev_bits,
    input  logic [ADDR_W-1:0]  idx,
    input  logic [ADDR_W-1:0]  cur,
    input  logic [ADDR_W-1:0]  col,
    input  logic [ADDR_W-1:0]  rowb,
    input  logic               dir,
    output logic [ADDR_W-1:0]  addr,
    output logic [ADDR_W-1:0]  nxt_cur,
    output logic [ADDR_W-1:0]  nxt_col,
    output logic [ADDR_W-1:0]  nxt_rowb,
    output logic               nxt_dir
);
    logic [ADDR_W-1:0] idx_rev;
    logic [RB_W-1:0]   shamt;
    logic [ADDR_W:0]   wsum;
    logic [ADDR_W:0]   wspan;
    logic [ADDR_W-1:0] col_inc;

    rf_agu_bitrev #(.W(ADDR_W)) u_rev (
        .din  (idx),
        .dout (idx_rev)
    );

    always_comb begin
        shamt   = RB_W'(ADDR_W) - rev_bits;
        wsum    = {1'b0, cur} + {1'b0, step};
        wspan   = {1'b0, hi} - {1'b0, lo} + (ADDR_W+1)'(1);
        col_inc = col + ADDR_W'(1);

        unique case (mode)
            M_BREV:   addr = base + (idx_rev >> shamt);
            M_ZIGZAG: addr = rowb + (dir ? (row_len - ADDR_W'(1) - col) : col);
            default:  addr = cur;
        endcase

        if (mode == M_CIRC && wsum > {1'b0, hi}) begin
            nxt_cur = ADDR_W'(wsum - wspan);
        end else begin
            nxt_cur = ADDR_W'(wsum);
        end

        if (col_inc == row_len) begin
            nxt_col  = '0;
            nxt_rowb = rowb + row_len;
            nxt_dir  = ~dir;
        end else begin
            nxt_col  = col_inc;
            nxt_rowb = rowb;
            nxt_dir  = dir;
        end
    end
endmodule

// File: rtl/rf_agu.sv
module rf_agu
    import rf_agu_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int DLY_W  = 8,
    parameter int REP_W  = 4,
    localparam int CNT_W = ADDR_W + 1,
    localparam int RB_W  = $clog2(ADDR_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [1:0]        cfg_mode,
    input  logic [ADDR_W-1:0] cfg_base,
    input  logic [ADDR_W-1:0] cfg_step,
    input  logic [CNT_W-1:0]  cfg_count,
    input  logic [ADDR_W-1:0] cfg_lo,
    input  logic [ADDR_W-1:0] cfg_hi,
    input  logic [ADDR_W-1:0] cfg_row_len,
    input  logic [RB_W-1:0]   cfg_rev_bits,
    input  logic [DLY_W-1:0]  cfg_init_dly,
    input  logic [DLY_W-1:0]  cfg_mid_dly,
    input  logic [DLY_W-1:0]  cfg_rep_dly,
    input  logic [REP_W-1:0]  cfg_repeat,
    output logic [ADDR_W-1:0] addr_o,
    output logic              addr_vld_o,
    output logic              done_o
);
    typedef struct packed {
        agu_state_e        st;
        logic [DLY_W-1:0]  tmr;
        logic [CNT_W-1:0]  idx;
        logic [REP_W-1:0]  pass;
        logic [ADDR_W-1:0] cur;
        logic [ADDR_W-1:0] col;
        logic [ADDR_W-1:0] rowb;
        logic              dir;
        logic              vld;
        logic [ADDR_W-1:0] addr;
        logic              done;
        agu_mode_e         mode;
        logic [ADDR_W-1:0] base;
        logic [ADDR_W-1:0] step;
        logic [ADDR_W-1:0] lo;
        logic [ADDR_W-1:0] hi;
        logic [ADDR_W-1:0] row_len;
        logic [RB_W-1:0]   rev_bits;
        logic [CNT_W-1:0]  count;
        logic [DLY_W-1:0]  mid;
        logic [DLY_W-1:0]  rep;
        logic [REP_W-1:0]  reps;
    } agu_reg_t;

    agu_reg_t          q, d;
    logic [DLY_W-1:0]  gap;
    logic [ADDR_W-1:0] pat_addr, pat_cur, pat_col, pat_rowb;
    logic              pat_dir;

    rf_agu_pattern #(.ADDR_W(ADDR_W)) u_pat (
        .mode     (q.mode),
        .base     (q.base),
        .step     (q.step),
        .lo       (q.lo),
        .hi       (q.hi),
        .row_len  (q.row_len),
        .rev_bits (q.rev_bits),
        .idx      (q.idx[ADDR_W-1:0]),
        .cur      (q.cur),
        .col      (q.col),
        .rowb     (q.rowb),
        .dir      (q.dir),
        .addr     (pat_addr),
        .nxt_cur  (pat_cur),
        .nxt_col  (pat_col),
        .nxt_rowb (pat_rowb),
        .nxt_dir  (pat_dir)
    );

    always_comb begin
        d      = q;
        d.vld  = 1'b0;
        d.done = 1'b0;
        gap    = '0;
        unique case (q.st)
            S_IDLE: begin
                if (start) begin
                    d.mode     = agu_mode_e'(cfg_mode);
                    d.base     = cfg_base;
                    d.step     = cfg_step;
                    d.lo       = cfg_lo;
                    d.hi       = cfg_hi;
                    d.row_len  = cfg_row_len;
                    d.rev_bits = cfg_rev_bits;
                    d.count    = cfg_count;
                    d.mid      = cfg_mid_dly;
                    d.rep      = cfg_rep_dly;
                    d.reps     = cfg_repeat;
                    d.idx      = '0;
                    d.pass     = '0;
                    d.cur      = cfg_base;
                    d.col      = '0;
                    d.rowb     = cfg_base;
                    d.dir      = 1'b0;
                    d.tmr      = cfg_init_dly;
                    d.st       = (cfg_init_dly == '0) ? S_EMIT : S_WAIT;
                end
            end
            S_WAIT: begin
                if (q.tmr == DLY_W'(1)) begin
                    d.st = S_EMIT;
                end else begin
                    d.tmr = q.tmr - DLY_W'(1);
                end
            end
            S_EMIT: begin
                d.vld  = 1'b1;
                d.addr = pat_addr;
                if ((q.idx + CNT_W'(1)) == q.count) begin
                    d.idx  = '0;
                    d.cur  = q.base;
                    d.col  = '0;
                    d.rowb = q.base;
                    d.dir  = 1'b0;
                    d.pass = q.pass + REP_W'(1);
                    gap    = q.rep;
                end else begin
                    d.idx  = q.idx + CNT_W'(1);
                    d.cur  = pat_cur;
                    d.col  = pat_col;
                    d.rowb = pat_rowb;
                    d.dir  = pat_dir;
                    gap    = q.mid;
                end
                d.tmr = gap;
                d.st  = (gap == '0) ? S_EMIT : S_WAIT;
                if ((q.idx + CNT_W'(1)) == q.count && q.pass == q.reps) begin
                    d.st = S_FIN;
                end
            end
            S_FIN: begin
                d.done = 1'b1;
                d.st   = S_IDLE;
            end
            default: d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign addr_o     = q.addr;
    assign addr_vld_o = q.vld;
    assign done_o     = q.done;
endmodule

// File: rtl/rf_agu_chk.sv
module rf_agu_chk #(
    parameter int ADDR_W = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              vld,
    input logic              done,
    input logic [ADDR_W-1:0] addr,
    input logic              busy,
    input logic              circ,
    input logic [ADDR_W-1:0] lo,
    input logic [ADDR_W-1:0] hi,
    input logic [ADDR_W-1:0] base_lat
);
    p_done_after_addr_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(vld));

    p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_done_no_strobe_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !vld);

    p_circ_window_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (vld && circ) |-> (addr >= lo && addr <= hi));

    p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> !vld);

    p_busy_start_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> $stable(base_lat));
endmodule

bind rf_agu rf_agu_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .vld      (addr_vld_o),
    .done     (done_o),
    .addr     (addr_o),
    .busy     (q.st != S_IDLE),
    .circ     (q.mode == M_CIRC),
    .lo       (q.lo),
    .hi       (q.hi),
    .base_lat (q.base)
);

// File: tb/rf_agu_tb_top.sv
`timescale 1ns/1ps
module rf_agu_tb_top;
    localparam int AW = 6;
    localparam int DW = 8;
    localparam int RW = 4;
    localparam int MASK = (1 << AW) - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [1:0]    cfg_mode = '0;
    logic [AW-1:0] cfg_base = '0, cfg_step = '0, cfg_lo = '0, cfg_hi = '0, cfg_row_len = '0;
    logic [AW:0]   cfg_count = '0;
    logic [2:0]    cfg_rev_bits = '0;
    logic [DW-1:0] cfg_init_dly = '0, cfg_mid_dly = '0, cfg_rep_dly = '0;
    logic [RW-1:0] cfg_repeat = '0;
    logic [AW-1:0] addr_o;
    logic          addr_vld_o, done_o;

    rf_agu #(.ADDR_W(AW), .DLY_W(DW), .REP_W(RW)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .cfg_mode(cfg_mode),
        .cfg_base(cfg_base), .cfg_step(cfg_step), .cfg_count(cfg_count),
        .cfg_lo(cfg_lo), .cfg_hi(cfg_hi), .cfg_row_len(cfg_row_len),
        .cfg_rev_bits(cfg_rev_bits), .cfg_init_dly(cfg_init_dly),
        .cfg_mid_dly(cfg_mid_dly), .cfg_rep_dly(cfg_rep_dly),
        .cfg_repeat(cfg_repeat), .addr_o(addr_o), .addr_vld_o(addr_vld_o),
        .done_o(done_o)
    );

    always #4 clk = ~clk;

    int    cyc = 0;
    int    checks = 0;
    int    errors = 0;
    int    last_done = 0;
    bit    chk_on = 1'b0;
    string tag = "R1";
    int    exp_addr[int];
    bit    exp_done[int];
    int    m_mode, m_base, m_step, m_count, m_lo, m_hi, m_row, m_rb, m_init, m_mid, m_rep, m_reps;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic report_end();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    always @(posedge clk) begin
        if (cyc > 50000) begin
            errors++;
            $display("FAIL watchdog expired at cycle %0d", cyc);
            report_end();
        end
    end

    function automatic int ref_addr(int j);
        int r, c, v;
        case (m_mode)
            0: v = m_base + j * m_step;
            1: v = m_lo + ((m_base - m_lo) + j * m_step) % (m_hi - m_lo + 1);
            2: begin
                r = 0;
                for (int b = 0; b < m_rb; b++)
                    if (((j >> b) & 1) != 0) r |= 1 << (m_rb - 1 - b);
                v = m_base + r;
            end
            default: begin
                r = j / m_row;
                c = j % m_row;
                v = m_base + r * m_row + (((r % 2) == 1) ? (m_row - 1 - c) : c);
            end
        endcase
        return v & MASK;
    endfunction

    // Per-cycle comparison against the reference schedule.
    always @(negedge clk) begin
        if (!rst_n) begin
            checks++;
            if (addr_vld_o !== 1'b0 || done_o !== 1'b0) begin
                errors++;
                $display("FAIL R1 in reset: vld=%0b done=%0b expected 0 0", addr_vld_o, done_o);
            end
        end else if (chk_on) begin
            bit ev, ed;
            ev = exp_addr.exists(cyc);
            ed = exp_done.exists(cyc);
            checks++;
            if (addr_vld_o !== ev) begin
                errors++;
                $display("FAIL R11/%s cycle %0d: vld=%0b expected %0b", tag, cyc, addr_vld_o, ev);
            end
            if (ev && addr_vld_o === 1'b1) begin
                checks++;
                if (int'(addr_o) != exp_addr[cyc]) begin
                    errors++;
                    $display("FAIL %s cycle %0d: addr=%0d expected %0d", tag, cyc, addr_o, exp_addr[cyc]);
                end
            end
            checks++;
            if (done_o !== ed) begin
                errors++;
                $display("FAIL R9/%s cycle %0d: done=%0b expected %0b", tag, cyc, done_o, ed);
            end
        end
    end

    task automatic set_cfg(int mode, int base, int step, int count, int lo, int hi,
                           int row, int rb, int init, int mid, int rep, int reps);
        cfg_mode = 2'(mode); cfg_base = AW'(base); cfg_step = AW'(step);
        cfg_count = 7'(count); cfg_lo = AW'(lo); cfg_hi = AW'(hi);
        cfg_row_len = AW'(row); cfg_rev_bits = 3'(rb); cfg_init_dly = DW'(init);
        cfg_mid_dly = DW'(mid); cfg_rep_dly = DW'(rep); cfg_repeat = RW'(reps);
    endtask

    // Called at a falling edge; start is sampled at the next rising edge.
    task automatic launch();
        int n, t;
        n = cyc + 1;
        start = 1'b1;
        if (n > last_done) begin
            m_mode = cfg_mode; m_base = cfg_base; m_step = cfg_step; m_count = cfg_count;
            m_lo = cfg_lo; m_hi = cfg_hi; m_row = cfg_row_len; m_rb = cfg_rev_bits;
            m_init = cfg_init_dly; m_mid = cfg_mid_dly; m_rep = cfg_rep_dly; m_reps = cfg_repeat;
            t = n + 1 + m_init;
            for (int p = 0; p <= m_reps; p++) begin
                for (int j = 0; j < m_count; j++) begin
                    exp_addr[t] = ref_addr(j);
                    if (j < m_count - 1) t += m_mid + 1;
                    else if (p < m_reps) t += m_rep + 1;
                end
            end
            exp_done[t + 1] = 1'b1;
            last_done = t + 1;
        end
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_idle();
        while (cyc <= last_done + 2) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        chk_on = 1'b1;
        repeat (4) @(negedge clk);

        tag = "R2";   // linear, zero delays back to back (R7)
        set_cfg(0, 3, 5, 20, 0, 0, 1, 1, 0, 0, 0, 0);
        launch(); wait_idle();

        tag = "R6";   // initial delay plus middle delay (R7)
        set_cfg(0, 60, 3, 6, 0, 0, 1, 1, 4, 2, 0, 0);
        launch(); wait_idle();

        tag = "R3";   // circular window wrap
        set_cfg(1, 20, 7, 15, 10, 25, 1, 1, 1, 0, 0, 0);
        launch(); wait_idle();
        set_cfg(1, 5, 4, 9, 5, 8, 1, 1, 0, 1, 0, 0);
        launch(); wait_idle();

        tag = "R4";   // bit-reverse over 4 bits and over full width
        set_cfg(2, 32, 0, 16, 0, 0, 1, 4, 0, 0, 0, 0);
        launch(); wait_idle();
        set_cfg(2, 0, 0, 64, 0, 0, 1, 6, 2, 1, 0, 0);
        launch(); wait_idle();

        tag = "R5";   // zig-zag rows of 5, then rows of 1
        set_cfg(3, 7, 0, 17, 0, 0, 5, 1, 0, 0, 0, 0);
        launch(); wait_idle();
        set_cfg(3, 62, 0, 4, 0, 0, 1, 1, 0, 0, 0, 0);
        launch(); wait_idle();

        tag = "R8";   // three passes with repetition gap
        set_cfg(0, 10, 1, 4, 0, 0, 1, 1, 2, 1, 3, 2);
        launch(); wait_idle();
        set_cfg(3, 0, 0, 6, 0, 0, 3, 1, 0, 0, 0, 1);
        launch(); wait_idle();

        tag = "R12";  // start and config change while busy (R10)
        set_cfg(0, 1, 2, 30, 0, 0, 1, 1, 0, 1, 0, 0);
        launch();
        repeat (10) @(negedge clk);
        set_cfg(2, 0, 9, 5, 0, 0, 1, 3, 0, 0, 0, 0);
        launch();
        repeat (5) @(negedge clk);
        cfg_base = 6'd40;
        wait_idle();

        tag = "R10";  // refused at the completion edge, accepted one edge later
        set_cfg(0, 50, 1, 3, 0, 0, 1, 1, 1, 0, 0, 0);
        launch();
        while (cyc < last_done - 1) @(negedge clk);
        set_cfg(1, 12, 3, 7, 10, 14, 1, 1, 0, 0, 0, 0);
        launch();
        launch();
        wait_idle();
        repeat (3) @(negedge clk);

        report_end();
    end
endmodule